// File: doc/BRIEF.md
# Line card control and interrupt register unit

This block sits on the byte-wide local bus of a four-span line card. The upper address bits pick one of four 256-byte transceiver windows, or the card's own small register bank just above them. For a window access it raises one chip select and passes the low address byte to that device. The register bank holds six functions:

- the clock sync source select
- a read-only status view
- the control word
- the LED drive
- the second test pin
- the framer revision mode

Most offsets map one register for both reads and writes. At the first bank offset they do not: a write there loads the sync source select, and a read there returns status.

The interrupt request joins two sources. One is a card-level pending flag. The other is the external framer interrupt, which is passed through only when its own enable bit is set. The pending flag is set by an event input. Software clears it by writing the control word with the acknowledge bit set. That bit is never stored.

The control word also drives the mode lines. With remote serial loopback set, the transmit serial output follows the receive serial input.

Top module: `card_ctrl_unit`

## Requirements
- R1: An access (read or write strobe) to offset 0x000-0x0FF, 0x100-0x1FF, 0x200-0x2FF or 0x300-0x3FF raises exactly chip select bit 0, 1, 2 or 3 in the same cycle. The low 8 address bits appear on the transceiver address output. With no access, or at offset 0x400 and above, no chip select is raised.
- R2: A write to 0x400 stores the low 3 data bits as the sync source. Values 1 to 4 appear on the sync select output. Values 0 and 5 to 7 give 0 (free run).
- R3: A read of 0x400 returns status in the same cycle: bit 0 interrupt enable, bit 1 card interrupt pending, bit 2 the framer interrupt input. Bits 7..3 are zero.
- R4: A write to 0x401 sets the control word from the data byte. Bit 0 is interrupt enable, bit 1 is the test1 output, bit 2 is framer interrupt enable, bit 3 is external sync enable, bit 4 is E1 divisor mode, bit 5 is remote loopback and bit 6 is local loopback. A read of 0x401 returns bits 6..0 with bit 7 reading as zero.
- R5: The framer interrupt input can raise the interrupt request only while control bit 2 is set.
- R6: A high card event input sets the pending flag at the next clock. A write to 0x401 with data bit 7 set clears it, unless an event arrives in the same cycle, in which case the event wins. The interrupt request is high while control bit 0 and the pending flag are both set.
- R7: With control bit 5 set, the transmit serial output equals the receive serial input. Otherwise it equals the transmit serial input.
- R8: A write to 0x402 sets the eight LED lines, which hold their value until the next such write. Bit 2k is the green line and bit 2k+1 the red line of span k+1. A read of 0x402 returns the value.
- R9: A write to 0x403 sets the test2 pin from data bit 0. A write to 0x404 sets revision mode from data bit 0. Reads of those offsets return the bit in position 0.
- R10: While reset is low, every register is zero: interrupts disabled, no pending flag, LEDs off, sync source free run, all mode and test outputs low.
- R11: Writes to offsets 0x405-0x7FF change no register. Reads there, reads of transceiver windows, and the read data whenever the read strobe is low are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 11 | Local bus byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle |
| xcvr_cs_o | output | 4 | Per-transceiver chip selects |
| xcvr_addr_o | output | 8 | Address byte passed to the transceivers |
| card_evt_i | input | 1 | Card-level interrupt event |
| framer_irq_i | input | 1 | Framer interrupt input |
| irq_o | output | 1 | Card interrupt request |
| rx_ser_i | input | 1 | Receive serial data |
| tx_ser_i | input | 1 | Transmit serial data from the card |
| tx_ser_o | output | 1 | Transmit serial data to the line |
| sync_sel_o | output | 3 | Sync source, 0 free run, 1..4 span |
| ext_sync_o | output | 1 | External sync enable |
| e1_mode_o | output | 1 | E1 divisor select |
| loop_local_o | output | 1 | Local serial loopback |
| test1_o | output | 1 | Test output 1 |
| test2_o | output | 1 | Test output 2 |
| rev_mode_o | output | 1 | Later-revision framer mode |
| led_o | output | 8 | LED lines, green/red pair per span |

## Verification
Every piece of state drives a port directly or through the read mux. A corrupted register shows on its mode line, on the LEDs or on the sync select at the next clock after the write that set it. A wrong pending flag shows on the interrupt request, and on status bit 1, one cycle after the event or acknowledge, provided interrupts are enabled. Decode faults show in the same cycle as the access, as a wrong chip select or as read data that comes from the wrong register. The bench therefore compares every output against a behavioural model on every cycle. It adds directed checks at the write/read aliasing offset, the acknowledge-versus-event collision and the out-of-range sync codes.

// File: rtl/card_ctrl_pkg.sv
`timescale 1ns/1ps
package card_ctrl_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SYNC_STAT,
    SEL_CTL,
    SEL_LED,
    SEL_TEST2,
    SEL_REV
  } reg_sel_e;

  // field order is the software-visible bit order, bit 6 down to bit 0
  typedef struct packed {
    logic loop_local;
    logic loop_remote;
    logic e1_mode;
    logic ext_sync;
    logic framer_en;
    logic test1;
    logic int_en;
  } ctl_t;

  localparam int CTL_ACK_BIT = 7;
  localparam int OFS_SYNC    = 0;
  localparam int OFS_CTL     = 1;
  localparam int OFS_LED     = 2;
  localparam int OFS_TEST2   = 3;
  localparam int OFS_REV     = 4;
endpackage

// File: rtl/card_addr_decode.sv
`timescale 1ns/1ps
module card_addr_decode
  import card_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int WIN_W    = 8,
  parameter int NUM_XCVR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NUM_XCVR-1:0] cs_o,
  output logic [WIN_W-1:0]  xaddr_o,
  output reg_sel_e          sel_o
);
  localparam int REG_W = ADDR_W - WIN_W;

  logic [REG_W-1:0] region;
  logic [WIN_W-1:0] ofs;
  logic             access;

  assign region  = addr_i[ADDR_W-1:WIN_W];
  assign ofs     = addr_i[WIN_W-1:0];
  assign access  = wr_i | rd_i;
  assign xaddr_o = ofs;

  for (genvar i = 0; i < NUM_XCVR; i++) begin : g_cs
    assign cs_o[i] = access && (region == REG_W'(i));
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (region == REG_W'(NUM_XCVR)) begin
      if      (ofs == WIN_W'(OFS_SYNC))  sel_o = SEL_SYNC_STAT;
      else if (ofs == WIN_W'(OFS_CTL))   sel_o = SEL_CTL;
      else if (ofs == WIN_W'(OFS_LED))   sel_o = SEL_LED;
      else if (ofs == WIN_W'(OFS_TEST2)) sel_o = SEL_TEST2;
      else if (ofs == WIN_W'(OFS_REV))   sel_o = SEL_REV;
    end
  end

  // R1
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  // R1
  cs_vs_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != SEL_NONE) |-> (cs_o == '0));
endmodule

// File: rtl/card_ctrl_regs.sv
`timescale 1ns/1ps
module card_ctrl_regs
  import card_ctrl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_XCVR = 4,
  parameter int SYNC_W   = $clog2(NUM_XCVR + 1),
  parameter int LED_W    = 2 * NUM_XCVR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [2:0]        status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SYNC_W-1:0] sync_sel_o,
  output ctl_t              ctl_o,
  output logic [LED_W-1:0]  led_o,
  output logic              test2_o,
  output logic              rev_o,
  output logic              ack_o
);
  localparam int CTL_W = $bits(ctl_t);

  logic [SYNC_W-1:0] sync_q;
  ctl_t              ctl_q;
  logic [LED_W-1:0]  led_q;
  logic              test2_q;
  logic              rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      ctl_q   <= '0;
      led_q   <= '0;
      test2_q <= 1'b0;
      rev_q   <= 1'b0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_SYNC_STAT: sync_q  <= wdata_i[SYNC_W-1:0];
        SEL_CTL:       ctl_q   <= ctl_t'(wdata_i[CTL_W-1:0]);
        SEL_LED:       led_q   <= wdata_i[LED_W-1:0];
        SEL_TEST2:     test2_q <= wdata_i[0];
        SEL_REV:       rev_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // acknowledge is a strobe, never stored
  assign ack_o = wr_i && (sel_i == SEL_CTL) && wdata_i[CTL_ACK_BIT];

  // out-of-range codes fall back to free run
  assign sync_sel_o = (sync_q != '0 && sync_q <= SYNC_W'(NUM_XCVR)) ? sync_q : '0;

  assign ctl_o   = ctl_q;
  assign led_o   = led_q;
  assign test2_o = test2_q;
  assign rev_o   = rev_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_SYNC_STAT: rdata_o = DATA_W'(status_i);
        SEL_CTL:       rdata_o = DATA_W'(ctl_q);
        SEL_LED:       rdata_o = DATA_W'(led_q);
        SEL_TEST2:     rdata_o = DATA_W'(test2_q);
        SEL_REV:       rdata_o = DATA_W'(rev_q);
        default:       rdata_o = '0;
      endcase
    end
  end

  // R2
  sync_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_sel_o <= SYNC_W'(NUM_XCVR));
  // R8
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == SEL_LED) |=> $stable(led_o));
  // R11
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: rtl/card_irq.sv
`timescale 1ns/1ps
module card_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_evt_i,
  input  logic ack_i,
  input  logic int_en_i,
  input  logic framer_en_i,
  input  logic framer_irq_i,
  output logic pending_o,
  output logic irq_o
);
  logic pend_q;

  // an event in the acknowledge cycle wins so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (card_evt_i) pend_q <= 1'b1;
    else if (ack_i)      pend_q <= 1'b0;
  end

  assign pending_o = pend_q;
  assign irq_o     = (int_en_i & pend_q) | (framer_en_i & framer_irq_i);

  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !card_evt_i) |=> !pending_o);
  // R6
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_evt_i |=> pending_o);
endmodule

// File: rtl/card_ctrl_unit.sv
`timescale 1ns/1ps
module card_ctrl_unit
  import card_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int WIN_W    = 8,
  parameter int NUM_XCVR = 4,
  parameter int SYNC_W   = $clog2(NUM_XCVR + 1),
  parameter int LED_W    = 2 * NUM_XCVR
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_XCVR-1:0] xcvr_cs_o,
  output logic [WIN_W-1:0]    xcvr_addr_o,
  input  logic                card_evt_i,
  input  logic                framer_irq_i,
  output logic                irq_o,
  input  logic                rx_ser_i,
  input  logic                tx_ser_i,
  output logic                tx_ser_o,
  output logic [SYNC_W-1:0]   sync_sel_o,
  output logic                ext_sync_o,
  output logic                e1_mode_o,
  output logic                loop_local_o,
  output logic                test1_o,
  output logic                test2_o,
  output logic                rev_mode_o,
  output logic [LED_W-1:0]    led_o
);
  reg_sel_e   sel;
  ctl_t       ctl;
  logic       ack;
  logic       pending;
  logic [2:0] status;

  card_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_XCVR(NUM_XCVR)
  ) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .cs_o    (xcvr_cs_o),
    .xaddr_o (xcvr_addr_o),
    .sel_o   (sel)
  );

  assign status = {framer_irq_i, pending, ctl.int_en};

  card_ctrl_regs #(
    .DATA_W(DATA_W), .NUM_XCVR(NUM_XCVR), .SYNC_W(SYNC_W), .LED_W(LED_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .sel_i      (sel),
    .wdata_i    (bus_wdata_i),
    .status_i   (status),
    .rdata_o    (bus_rdata_o),
    .sync_sel_o (sync_sel_o),
    .ctl_o      (ctl),
    .led_o      (led_o),
    .test2_o    (test2_o),
    .rev_o      (rev_mode_o),
    .ack_o      (ack)
  );

  card_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .card_evt_i   (card_evt_i),
    .ack_i        (ack),
    .int_en_i     (ctl.int_en),
    .framer_en_i  (ctl.framer_en),
    .framer_irq_i (framer_irq_i),
    .pending_o    (pending),
    .irq_o        (irq_o)
  );

  assign tx_ser_o     = ctl.loop_remote ? rx_ser_i : tx_ser_i;
  assign ext_sync_o   = ctl.ext_sync;
  assign e1_mode_o    = ctl.e1_mode;
  assign loop_local_o = ctl.loop_local;
  assign test1_o      = ctl.test1;

  // R5
  framer_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.framer_en && !ctl.int_en) |-> !irq_o);
  // R7
  remote_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.loop_remote |-> (tx_ser_o == rx_ser_i));
  // R3
  status_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && sel == SEL_SYNC_STAT) |-> (bus_rdata_o[2] == framer_irq_i));
endmodule

// File: tb/card_ctrl_unit_tb.sv
`timescale 1ns/1ps
module card_ctrl_unit_tb_top;
  localparam real HALF = 2.5; // 200 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic        evt = 1'b0, fint = 1'b0, rx = 1'b0, txi = 1'b0;
  logic [7:0]  rdata;
  logic [3:0]  cs;
  logic [7:0]  xaddr;
  logic        irq, txo, ext, e1, lloop, t1, t2, rev;
  logic [2:0]  sync;
  logic [7:0]  led;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  card_ctrl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata), .xcvr_cs_o(cs),
    .xcvr_addr_o(xaddr), .card_evt_i(evt), .framer_irq_i(fint), .irq_o(irq),
    .rx_ser_i(rx), .tx_ser_i(txi), .tx_ser_o(txo), .sync_sel_o(sync),
    .ext_sync_o(ext), .e1_mode_o(e1), .loop_local_o(lloop), .test1_o(t1),
    .test2_o(t2), .rev_mode_o(rev), .led_o(led)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int m_sync, m_ctl, m_led, m_t2, m_rev, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_ctl = 0; m_led = 0; m_t2 = 0; m_rev = 0; m_pend = 0;
    end else begin
      bit ackw;
      ackw = 0;
      if (wr) begin
        case (int'(addr))
          1024: m_sync = wdata % 8;
          1025: begin m_ctl = wdata % 128; ackw = wdata[7]; end
          1026: m_led = wdata;
          1027: m_t2 = wdata % 2;
          1028: m_rev = wdata % 2;
          default: ;
        endcase
      end
      if (evt) m_pend = 1;
      else if (ackw) m_pend = 0;
    end
  end

  function automatic int bit_of(int v, int b);
    return (v >> b) & 1;
  endfunction

  // full comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, e_cs, e_rd, e_sync, e_irq;
      a = int'(addr);
      e_cs = ((rd || wr) && a < 1024) ? (1 << (a / 256)) : 0;
      e_sync = (m_sync >= 1 && m_sync <= 4) ? m_sync : 0;
      e_irq = (bit_of(m_ctl, 0) && m_pend) || (bit_of(m_ctl, 2) && fint) ? 1 : 0;
      e_rd = 0;
      if (rd) begin
        case (a)
          1024: e_rd = bit_of(m_ctl, 0) | (m_pend << 1) | (int'(fint) << 2);
          1025: e_rd = m_ctl;
          1026: e_rd = m_led;
          1027: e_rd = m_t2;
          1028: e_rd = m_rev;
          default: e_rd = 0;
        endcase
      end
      chk("R1 cs", cs, e_cs);
      chk("R1 xaddr", xaddr, a % 256);
      chk("R2 sync", sync, e_sync);
      chk("R3 R11 rdata", rdata, e_rd);
      chk("R4 test1", t1, bit_of(m_ctl, 1));
      chk("R4 ext_sync", ext, bit_of(m_ctl, 3));
      chk("R4 e1", e1, bit_of(m_ctl, 4));
      chk("R4 local_loop", lloop, bit_of(m_ctl, 6));
      chk("R5 R6 irq", irq, e_irq);
      chk("R7 tx_ser", txo, bit_of(m_ctl, 5) ? int'(rx) : int'(txi));
      chk("R8 led", led, m_led);
      chk("R9 test2", t2, m_t2);
      chk("R9 rev", rev, m_rev);
    end
  end

  task automatic bus_wr(input int a, input int d);
    @(negedge clk); #0.5;
    addr = 11'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk); #0.5;
    wr = 1'b0;
  endtask

  task automatic bus_rd(input int a, output int d, output int c);
    @(negedge clk); #0.5;
    addr = 11'(a); rd = 1'b1;
    #1;
    d = int'(rdata); c = int'(cs);
    @(negedge clk); #0.5;
    rd = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk); #0.5; evt = 1'b1;
    @(negedge clk); #0.5; evt = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20000.0);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d, c;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 led", led, 0);
    chk("R10 sync", sync, 0);
    chk("R10 modes", {ext, e1, lloop, t1, t2, rev}, 0);
    #0.5 rst_n = 1'b1;

    // R1 window decode
    for (int w = 0; w < 4; w++) begin
      bus_rd(w * 256 + 8'h5A, d, c);
      chk("R1 window cs", c, 1 << w);
      chk("R11 xcvr read zero", d, 0);
    end
    bus_rd(1024, d, c);
    chk("R1 bank no cs", c, 0);

    // R2 sync codes incl. out-of-range
    for (int v = 0; v < 8; v++) begin
      bus_wr(1024, 8'hF8 | v);
      chk("R2 sync code", sync, (v >= 1 && v <= 4) ? v : 0);
    end

    // R4 control layout
    bus_wr(1025, 8'h5A);
    chk("R4 pattern A", {lloop, e1, ext, t1}, 4'hF);
    bus_rd(1025, d, c);
    chk("R4 readback A", d, 8'h5A);
    bus_wr(1025, 8'hA5);
    bus_rd(1025, d, c);
    chk("R4 ack reads zero", d, 8'h25);

    // R7 remote loopback on (bit 5 set above)
    @(negedge clk); #0.5; rx = 1; txi = 0; #1;
    chk("R7 loop rx=1", txo, 1);
    @(negedge clk); #0.5; rx = 0; txi = 1; #1;
    chk("R7 loop rx=0", txo, 0);
    bus_wr(1025, 8'h00);
    #1 chk("R7 normal path", txo, 1);

    // R5 framer gating
    @(negedge clk); #0.5; fint = 1; #1;
    chk("R5 gated off", irq, 0);
    bus_rd(1024, d, c);
    chk("R3 status framer", d, 8'h04);
    bus_wr(1025, 8'h04);
    chk("R5 gated on", irq, 1);
    bus_wr(1025, 8'h00);
    @(negedge clk); #0.5; fint = 0;

    // R6 card interrupt
    bus_wr(1025, 8'h01);
    pulse_evt();
    chk("R6 irq set", irq, 1);
    bus_rd(1024, d, c);
    chk("R3 status pend", d, 8'h03);
    bus_wr(1025, 8'h81);
    chk("R6 ack clears", irq, 0);
    bus_wr(1025, 8'h00);
    pulse_evt();
    chk("R6 masked", irq, 0);
    bus_rd(1024, d, c);
    chk("R3 status masked pend", d, 8'h02);
    // ack and event collide: event wins
    @(negedge clk); #0.5;
    addr = 11'd1025; wdata = 8'h81; wr = 1; evt = 1;
    @(negedge clk); #0.5;
    wr = 0; evt = 0;
    chk("R6 event wins", irq, 1);
    bus_wr(1025, 8'h81);
    chk("R6 ack after collide", irq, 0);

    // R8 LEDs
    bus_wr(1026, 8'h01);
    chk("R8 span1 green", led, 8'h01);
    bus_wr(1026, 8'h03);
    chk("R8 span1 yellow", led, 8'h03);
    bus_wr(1026, 8'hC0);
    bus_rd(1026, d, c);
    chk("R8 readback", d, 8'hC0);

    // R9 test2 and revision
    bus_wr(1027, 8'hFF);
    chk("R9 test2 set", t2, 1);
    bus_wr(1028, 8'h01);
    chk("R9 rev set", rev, 1);
    bus_rd(1027, d, c);
    chk("R9 test2 read", d, 1);
    bus_wr(1027, 8'hFE);
    chk("R9 test2 clear", t2, 0);

    // R11 unmapped writes ignored
    bus_wr(1029, 8'hFF);
    bus_wr(2047, 8'hFF);
    bus_rd(1026, d, c);
    chk("R11 led kept", d, 8'hC0);
    bus_rd(1025, d, c);
    chk("R11 ctl kept", d, 8'h01);
    bus_rd(1029, d, c);
    chk("R11 unmapped read", d, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule